// File: doc/BRIEF.md
# SDRAM Idle Low-Power Entry Controller

This block sits beside an SDRAM access engine and decides when the attached memory may be put into a low-power state and when it must be woken again. It follows the engine's access requests and end-of-transfer pulses. It counts idle cycles against a selectable timeout. When the timeout runs out, it asks the command sequencer for one of three entry commands: self-refresh, power-down or deep power-down. It also drives the clock-enable pin and a gate for the device clock.

When an access arrives while the device sleeps in self-refresh or power-down, the block raises the clock-enable pin at once. It holds the host back through its ready output for a fixed exit delay, lets the access through, and sleeps again once the access has ended and the timeout has run out again. Deep power-down is only entered when the attached device is flagged as a low-power part. That state does not wake on accesses: it is left only when the configuration stops selecting deep power-down.

Top module: `sdram_lp_ctrl`

## Requirements
- R1: Out of reset, cke, dev_clk_en and host_ready are 1 and cmd_req is 0.
- R2: With lp_cfg = 0, or lp_cfg = 3 while dev_is_lp = 0, no entry command is ever issued and cke stays 1.
- R3: Timeout select tmo_sel 0, 1, 2 and 3 give idle limits of 0, P_TMO_SHORT (64), P_TMO_LONG (128) and 0 cycles. With no new access, cke falls on the clock edge that lies limit + 1 edges after the edge that samples xfer_done.
- R4: Self-refresh (lp_cfg = 1) entry raises cmd_req for exactly one cycle with cmd_code = 1, in the first cycle in which cke is 0. From that cycle on, dev_clk_en is 0.
- R5: Power-down (lp_cfg = 2) entry issues cmd_code = 2 with cke at 0, and dev_clk_en stays 1.
- R6: Deep power-down (lp_cfg = 3, dev_is_lp = 1) issues cmd_code = 3 with cke and dev_clk_en at 0. While asleep it ignores acc_req: cke and host_ready stay 0. It wakes through the self-refresh exit path on the first edge that samples lp_cfg != 3.
- R7: An acc_req sampled while asleep in self-refresh sets cke and dev_clk_en to 1 in the next cycle. host_ready then stays 0 for P_SR_EXIT cycles before it returns to 1.
- R8: An acc_req sampled while asleep in power-down keeps host_ready at 0 for P_PD_EXIT (1) cycle before it returns to 1.
- R9: After a woken access completes (xfer_done), the configured mode is re-entered with the timing of R3.
- R10: An access that starts during the idle countdown restarts the count from zero. No entry happens while acc_req is high or an access is in flight.
- R11: host_ready is 0 in every cycle in which cke is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_cfg | input | 2 | Low-power mode: 0 off, 1 self-refresh, 2 power-down, 3 deep power-down |
| tmo_sel | input | 2 | Idle timeout select: 0 none, 1 short, 2 long, 3 none |
| dev_is_lp | input | 1 | Attached device is a low-power SDRAM |
| acc_req | input | 1 | Host access request, held until host_ready is seen |
| xfer_done | input | 1 | One-cycle pulse at the end of a transfer |
| cke | output | 1 | Clock-enable pin of the device |
| dev_clk_en | output | 1 | Enable for the device clock gate |
| cmd_req | output | 1 | One-cycle request for an entry command |
| cmd_code | output | 2 | Entry command: 1 self-refresh, 2 power-down, 3 deep power-down |
| host_ready | output | 1 | Host may proceed with its access |

## Verification
Entry is due limit + 1 edges after the edge that samples xfer_done. After that edge the bench steps one falling edge at a time and counts the falling edges until cke drops, then compares the count with the limit plus one. cmd_req, cmd_code and dev_clk_en are compared at that same sample, and one sample later for the end of the pulse. A wake-up shows cke high at the first falling edge after the request edge. The bench then counts the falling edges at which host_ready is low and expects exactly the exit delay of the mode it latched at entry. Because inputs change and outputs are sampled only at falling edges, each count lines up with the registered state without any race.

// File: rtl/sdram_lp_pkg.sv
package sdram_lp_pkg;

   // Entry mode; values double as the command code seen by the sequencer.
   typedef enum logic [1:0] {
      LP_OFF   = 2'd0,
      LP_SELF  = 2'd1,
      LP_PDOWN = 2'd2,
      LP_DEEP  = 2'd3
   } lp_mode_e;

   typedef enum logic [1:0] {
      ST_AWAKE  = 2'd0,
      ST_ASLEEP = 2'd1,
      ST_WAKING = 2'd2
   } lp_state_e;

endpackage

// File: rtl/sdram_lp_mode_sel.sv
module sdram_lp_mode_sel
   import sdram_lp_pkg::*;
(
   input  logic [1:0] cfg,
   input  logic       dev_lp,
   output lp_mode_e   mode
);

   // Deep power-down only exists on low-power parts; otherwise stay off.
   always_comb begin
      mode = lp_mode_e'(cfg);
      if (cfg == 2'd3 && !dev_lp)
         mode = LP_OFF;
   end

endmodule

// File: rtl/sdram_lp_idle_timer.sv
module sdram_lp_idle_timer #(
   parameter int P_SHORT = 64,
   parameter int P_LONG  = 128
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear,
   input  logic [1:0] tmo_sel,
   output logic       expired
);

   localparam int CW = $clog2(P_LONG + 1);

   logic [CW-1:0] cnt;
   logic [CW-1:0] limit;

   generate
      if (P_SHORT < 1 || P_LONG <= P_SHORT) begin : g_bad_limits
         $error("idle timer: need 1 <= P_SHORT < P_LONG");
      end
   endgenerate

   always_comb begin
      case (tmo_sel)
         2'd1:    limit = CW'(P_SHORT);
         2'd2:    limit = CW'(P_LONG);
         default: limit = '0;
      endcase
   end

   // Saturates at the long limit so a long idle spell never wraps.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clear)
         cnt <= '0;
      else if (cnt != CW'(P_LONG))
         cnt <= cnt + 1'b1;
   end

   assign expired = (cnt >= limit);

endmodule

// File: rtl/sdram_lp_exit_timer.sv
module sdram_lp_exit_timer #(
   parameter int P_W = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [P_W-1:0] load_val,
   input  logic           run,
   output logic           done
);

   logic [P_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (run && cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);

endmodule

// File: rtl/sdram_lp_ctrl.sv
module sdram_lp_ctrl
   import sdram_lp_pkg::*;
#(
   parameter int P_TMO_SHORT = 64,
   parameter int P_TMO_LONG  = 128,
   parameter int P_SR_EXIT   = 6,
   parameter int P_PD_EXIT   = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] lp_cfg,
   input  logic [1:0] tmo_sel,
   input  logic       dev_is_lp,
   input  logic       acc_req,
   input  logic       xfer_done,
   output logic       cke,
   output logic       dev_clk_en,
   output logic       cmd_req,
   output logic [1:0] cmd_code,
   output logic       host_ready
);

   localparam int XMAX = (P_SR_EXIT > P_PD_EXIT) ? P_SR_EXIT : P_PD_EXIT;
   localparam int XW   = $clog2(XMAX + 1);

   generate
      if (P_SR_EXIT < 1 || P_PD_EXIT < 1) begin : g_bad_exit
         $error("lp ctrl: exit delays must be at least one cycle");
      end
   endgenerate

   lp_state_e state;
   lp_mode_e  held_mode;
   lp_mode_e  want_mode;
   logic      busy;
   logic      idle_clear;
   logic      idle_expired;
   logic      go_sleep;
   logic      wake;
   logic      exit_done;
   logic [XW-1:0] exit_val;
   logic      cmd_req_q;
   logic [1:0] cmd_code_q;

   sdram_lp_mode_sel u_mode (
      .cfg    (lp_cfg),
      .dev_lp (dev_is_lp),
      .mode   (want_mode)
   );

   sdram_lp_idle_timer #(
      .P_SHORT (P_TMO_SHORT),
      .P_LONG  (P_TMO_LONG)
   ) u_idle (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (idle_clear),
      .tmo_sel (tmo_sel),
      .expired (idle_expired)
   );

   sdram_lp_exit_timer #(
      .P_W (XW)
   ) u_exit (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wake),
      .load_val (exit_val),
      .run      (state == ST_WAKING),
      .done     (exit_done)
   );

   // Any activity, or not being awake, holds the idle count at zero.
   assign idle_clear = (state != ST_AWAKE) || busy || acc_req;
   assign go_sleep   = (state == ST_AWAKE) && !idle_clear && idle_expired &&
                       (want_mode != LP_OFF);
   assign wake       = (state == ST_ASLEEP) &&
                       ((held_mode == LP_DEEP) ? (lp_cfg != 2'd3) : acc_req);
   assign exit_val   = (held_mode == LP_PDOWN) ? XW'(P_PD_EXIT - 1)
                                               : XW'(P_SR_EXIT - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_AWAKE;
         held_mode <= LP_OFF;
      end else begin
         case (state)
            ST_AWAKE: if (go_sleep) begin
               state     <= ST_ASLEEP;
               held_mode <= want_mode;
            end
            ST_ASLEEP: if (wake) state <= ST_WAKING;
            ST_WAKING: if (exit_done) state <= ST_AWAKE;
            default:   state <= ST_AWAKE;
         endcase
      end
   end

   // An access is in flight from its acceptance until its end pulse.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         busy <= 1'b0;
      else
         busy <= (busy && !xfer_done) || (acc_req && state == ST_AWAKE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_req_q  <= 1'b0;
         cmd_code_q <= 2'd0;
      end else begin
         cmd_req_q <= go_sleep;
         if (go_sleep)
            cmd_code_q <= want_mode;
      end
   end

   assign cke        = (state != ST_ASLEEP);
   assign dev_clk_en = !((state == ST_ASLEEP) && (held_mode != LP_PDOWN));
   assign host_ready = (state == ST_AWAKE);
   assign cmd_req    = cmd_req_q;
   assign cmd_code   = cmd_code_q;

endmodule

// File: rtl/sdram_lp_ctrl_chk.sv
module sdram_lp_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] lp_cfg,
   input logic       dev_is_lp,
   input logic       acc_req,
   input logic       cke,
   input logic       dev_clk_en,
   input logic       cmd_req,
   input logic [1:0] cmd_code,
   input logic       host_ready
);

   p_ready_needs_cke_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |-> !host_ready);

   p_cmd_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_req |=> !cmd_req);

   p_cmd_on_cke_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cke) |-> cmd_req);

   p_self_gates_clk_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req && cmd_code == 2'd1) |-> (!dev_clk_en && !cke));

   p_pdown_clocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req && cmd_code == 2'd2) |-> (dev_clk_en && !cke));

   p_deep_lp_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req && cmd_code == 2'd3) |-> ($past(dev_is_lp) && !dev_clk_en));

   p_off_no_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_req |-> ($past(lp_cfg) != 2'd0));

   p_wake_holds_host_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cke) |-> (!host_ready && dev_clk_en));

   p_no_entry_on_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_req |-> !$past(acc_req));

endmodule

bind sdram_lp_ctrl sdram_lp_ctrl_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .lp_cfg     (lp_cfg),
   .dev_is_lp  (dev_is_lp),
   .acc_req    (acc_req),
   .cke        (cke),
   .dev_clk_en (dev_clk_en),
   .cmd_req    (cmd_req),
   .cmd_code   (cmd_code),
   .host_ready (host_ready)
);

// File: tb/sdram_lp_ctrl_tb.sv
module sdram_lp_ctrl_tb;

   localparam int CLK_PERIOD = 10;
   localparam int T_SHORT    = 64;
   localparam int T_LONG     = 128;
   localparam int SR_X       = 6;
   localparam int PD_X       = 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] lp_cfg = 2'd0;
   logic [1:0] tmo_sel = 2'd0;
   logic       dev_is_lp = 1'b0;
   logic       acc_req = 1'b0;
   logic       xfer_done = 1'b0;
   logic       cke, dev_clk_en, cmd_req, host_ready;
   logic [1:0] cmd_code;

   int n_chk = 0;
   int n_err = 0;
   int asleep_mode = 0;   // 0 awake, else latched mode code

   always #(CLK_PERIOD/2) clk = ~clk;

   sdram_lp_ctrl #(
      .P_TMO_SHORT (T_SHORT),
      .P_TMO_LONG  (T_LONG),
      .P_SR_EXIT   (SR_X),
      .P_PD_EXIT   (PD_X)
   ) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .lp_cfg     (lp_cfg),
      .tmo_sel    (tmo_sel),
      .dev_is_lp  (dev_is_lp),
      .acc_req    (acc_req),
      .xfer_done  (xfer_done),
      .cke        (cke),
      .dev_clk_en (dev_clk_en),
      .cmd_req    (cmd_req),
      .cmd_code   (cmd_code),
      .host_ready (host_ready)
   );

   function automatic int f_limit(int t);
      if (t == 1) return T_SHORT;
      if (t == 2) return T_LONG;
      return 0;
   endfunction

   function automatic int f_code(int c, bit lp);
      if (c == 3 && !lp) return 0;
      return c;
   endfunction

   function automatic int f_wake(int m);
      if (m == 2) return PD_X;
      if (m == 1 || m == 3) return SR_X;
      return 0;
   endfunction

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   // New settings go in with the request so no stale expiry fires first.
   task automatic do_access(int cfg, int tmo, bit lp, int gap);
      int w;
      bit was_asleep;
      string tag;
      was_asleep = (asleep_mode != 0);
      tag = (asleep_mode == 2) ? "R8 power-down exit hold" : "R7 self-refresh exit hold";
      lp_cfg = 2'(cfg); tmo_sel = 2'(tmo); dev_is_lp = lp; acc_req = 1'b1;
      step();
      if (was_asleep) begin
         check("R7 cke up after wake", int'(cke), 1);
         check("R7 clock on after wake", int'(dev_clk_en), 1);
      end
      w = 0;
      while (!host_ready && w < 1000) begin w++; step(); end
      check(tag, w, f_wake(asleep_mode));
      asleep_mode = 0;
      step();
      acc_req = 1'b0;
      repeat (gap) step();
      xfer_done = 1'b1;
      step();
      xfer_done = 1'b0;
   endtask

   task automatic watch_entry(string req);
      int lim, c, n;
      lim = f_limit(int'(tmo_sel));
      c = f_code(int'(lp_cfg), dev_is_lp);
      n = 0;
      while (cke && n < 300) begin step(); n++; end
      if (c == 0) begin
         check({req, " R2 stays awake"}, n, 300);
      end else begin
         check({req, " R3 entry edge"}, n, lim + 1);
         check({req, " R4 cmd pulse"}, int'(cmd_req), 1);
         check({req, " cmd code"}, int'(cmd_code), c);
         check({req, " R5 clock enable"}, int'(dev_clk_en), (c == 2) ? 1 : 0);
         check({req, " R11 host held"}, int'(host_ready), 0);
         step();
         check({req, " R4 pulse ends"}, int'(cmd_req), 0);
         check({req, " cke stays low"}, int'(cke), 0);
         asleep_mode = c;
      end
   endtask

   task automatic wake_deep();
      int w;
      lp_cfg = 2'd0;
      step();
      w = 0;
      while (!host_ready && w < 1000) begin w++; step(); end
      check("R6 deep exit hold", w, SR_X);
      check("R6 cke after deep exit", int'(cke), 1);
      asleep_mode = 0;
   endtask

   initial begin
      step(); step(); step();
      rst_n = 1'b1;
      step();
      check("R1 cke", int'(cke), 1);
      check("R1 clock enable", int'(dev_clk_en), 1);
      check("R1 ready", int'(host_ready), 1);
      check("R1 cmd_req", int'(cmd_req), 0);

      do_access(1, 0, 0, 3); watch_entry("R4 self-refresh tmo0");
      do_access(1, 1, 0, 2); watch_entry("R9 re-entry tmo1");
      do_access(2, 2, 0, 1); watch_entry("R5 power-down tmo2");
      do_access(2, 3, 0, 0); watch_entry("R3 tmo3 as zero");
      do_access(0, 0, 1, 2); watch_entry("R2 disabled");
      do_access(3, 0, 0, 2); watch_entry("R2 deep without lp flag");

      // R10: a request in mid countdown restarts it.
      do_access(1, 1, 0, 1);
      repeat (40) step();
      check("R10 awake mid countdown", int'(cke), 1);
      do_access(1, 1, 0, 1); watch_entry("R10 restarted count");

      // R6: deep power-down ignores accesses.
      do_access(3, 0, 1, 2); watch_entry("R6 deep entry");
      acc_req = 1'b1;
      repeat (20) step();
      check("R6 access ignored cke", int'(cke), 0);
      check("R6 access ignored ready", int'(host_ready), 0);
      acc_req = 1'b0;
      wake_deep();

      void'($urandom(32'd1234));
      for (int it = 0; it < 12; it++) begin
         int cfg, tmo, gap, lim;
         bit lp, intr;
         if (asleep_mode == 3) wake_deep();
         cfg = int'($urandom % 4);
         tmo = int'($urandom % 4);
         lp  = 1'($urandom % 2);
         gap = int'($urandom % 5);
         intr = 1'($urandom % 2);
         do_access(cfg, tmo, lp, gap);
         lim = f_limit(tmo);
         if (intr && lim > 0 && f_code(cfg, lp) != 0) begin
            repeat (int'($urandom % lim)) step();
            check("R10 no early entry", int'(cke), 1);
            do_access(cfg, tmo, lp, gap);
         end
         watch_entry("R9 random");
      end

      report();
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=done");
      report();
      $finish;
   end

endmodule